// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache placed between a processor's load/store path and a word-wide memory. Each block holds one 32-bit word, and each set holds two ways. A processor request carries an address, a read/write flag, four byte enables and write data. It is accepted when `cpu_valid` and `cpu_ready` are both high. The result appears as a one-cycle `cpu_resp_valid` pulse with `cpu_rdata`.

On a hit, the response comes back in the next cycle and the cache can take another request at once. On a miss, the cache lowers `cpu_ready`. If the least recently used way of the set holds modified data, that word is first written back to memory. The requested word is then fetched, installed, merged with any write data, and returned. Writes never go straight to memory: a written line is marked dirty and reaches memory only when it is evicted. A write miss first brings the word into the cache.

Top module: `cache2w_top`

## Requirements
- R1: After reset every line is invalid: `cpu_ready` is 1, `cpu_resp_valid` and `mem_req` are 0, and the first access to any address is a miss.
- R2: Address bits [1:0] are ignored for lookup, bits [SET_BITS+1:2] select the set, and the bits above them form the tag. A request hits when a valid way of its set holds a matching tag, and at most one way can match.
- R3: Two words that share a set can be resident together. Alternating reads of byte addresses 0x0 and 0x10 (same set with SET_BITS=2) eight times give exactly two misses followed by six hits.
- R4: Each set keeps one recency bit. A hit or a fill marks the used way as most recent, and a miss replaces the least recent way.
- R5: A write hit changes only the byte lanes whose `cpu_be` bit is 1 (bit b covers data bits 8b+7..8b) and marks the line dirty. It causes no memory transaction.
- R6: A read hit raises `cpu_resp_valid` with the stored word in the cycle after acceptance, and `cpu_ready` stays high.
- R7: On a miss, `cpu_ready` is low and `cpu_resp_valid` is 0 from the cycle after acceptance until the response. The response arrives with `cpu_ready` high again.
- R8: Once `mem_req` is raised, it stays high with stable `mem_addr` and `mem_we` until `mem_ack` is seen.
- R9: A miss whose victim is valid and dirty first writes the victim's word (`mem_we`=1) to the victim's own address, then reads the new word. A clean victim causes no write.
- R10: A write miss fetches the target word, merges the write data under the byte enables, and leaves the line valid and dirty. Memory is not written until the line is evicted.
- R11: Every read returns the value that a flat byte-enabled memory, holding all earlier writes, would return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; invalidates all lines |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Cache can accept a request this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_be | input | 4 | Byte enables for a write |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_wdata | input | 32 | Write data |
| cpu_resp_valid | output | 1 | One-cycle pulse: request completed |
| cpu_rdata | output | 32 | Word returned with the response |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write-back, 0 = fetch |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | 32 | Data for a write-back |
| mem_ack | input | 1 | One-cycle pulse ending the memory transaction |
| mem_rdata | input | 32 | Fetched word, valid with `mem_ack` |

## Verification
The assertions assume a memory that answers each request with exactly one `mem_ack` pulse, and only while `mem_req` is high. They also assume that `cpu_valid` is only examined while the cache is idle. The bench memory model returns an acknowledge after a fixed latency and then drops it in the next cycle. The processor side raises `cpu_valid` for a single accepted cycle and then waits for the response before it issues the next request, so the request fields never change during a miss.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
   localparam int WORD_W = 32;
   localparam int LANES  = WORD_W / 8;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WBACK = 2'd1,
      ST_FETCH = 2'd2,
      ST_FILL  = 2'd3
   } cstate_e;

   function automatic logic [WORD_W-1:0] merge_lanes(
      input logic [WORD_W-1:0] base,
      input logic [WORD_W-1:0] upd,
      input logic [LANES-1:0]  sel);
      logic [WORD_W-1:0] r;
      r = base;
      for (int b = 0; b < LANES; b++)
         if (sel[b]) r[8*b +: 8] = upd[8*b +: 8];
      return r;
   endfunction
endpackage

// File: rtl/cache2w_tags.sv
module cache2w_tags
   import cache2w_pkg::*;
#(
   parameter int SET_BITS = 2,
   parameter int TAG_W    = 28
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SET_BITS-1:0] lk_idx,
   input  logic [TAG_W-1:0]    lk_tag,
   output logic [1:0]          hit_way,
   output logic                vic_way,
   output logic                vic_valid,
   output logic                vic_dirty,
   output logic [TAG_W-1:0]    vic_tag,
   input  logic                wr_en,
   input  logic [SET_BITS-1:0] wr_idx,
   input  logic                wr_way,
   input  logic [TAG_W-1:0]    wr_tag,
   input  logic                wr_dirty,
   input  logic                touch_en,
   input  logic [SET_BITS-1:0] touch_idx,
   input  logic                touch_way
);
   localparam int SETS = 1 << SET_BITS;

   logic [SETS-1:0]           lru_q;   // way to replace next
   logic [1:0][TAG_W-1:0]     tag_rd;
   logic [1:0]                val_rd;
   logic [1:0]                dty_rd;

   generate
      for (genvar w = 0; w < 2; w++) begin : g_way
         logic [TAG_W-1:0] tag_q [SETS];
         logic [SETS-1:0]  val_q;
         logic [SETS-1:0]  dty_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               val_q <= '0;
               dty_q <= '0;
            end else if (wr_en && wr_way == 1'(w)) begin
               val_q[wr_idx] <= 1'b1;
               dty_q[wr_idx] <= wr_dirty;
            end
         end

         always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w)) tag_q[wr_idx] <= wr_tag;
         end

         assign tag_rd[w]  = tag_q[lk_idx];
         assign val_rd[w]  = val_q[lk_idx];
         assign dty_rd[w]  = dty_q[lk_idx];
         assign hit_way[w] = val_rd[w] && (tag_rd[w] == lk_tag);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lru_q <= '0;
      else if (touch_en) lru_q[touch_idx] <= ~touch_way;
   end

   assign vic_way   = lru_q[lk_idx];
   assign vic_valid = val_rd[vic_way];
   assign vic_dirty = dty_rd[vic_way];
   assign vic_tag   = tag_rd[vic_way];

   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_way)) else $error("two ways hold the same tag"); // R2
endmodule

// File: rtl/cache2w_data.sv
module cache2w_data
   import cache2w_pkg::*;
#(
   parameter int SET_BITS = 2
)(
   input  logic                   clk,
   input  logic [SET_BITS-1:0]    rd_idx,
   output logic [1:0][WORD_W-1:0] rd_word,
   input  logic                   wr_en,
   input  logic [SET_BITS-1:0]    wr_idx,
   input  logic                   wr_way,
   input  logic [LANES-1:0]       wr_be,
   input  logic [WORD_W-1:0]      wr_word
);
   localparam int SETS = 1 << SET_BITS;

   generate
      for (genvar w = 0; w < 2; w++) begin : g_way
         logic [WORD_W-1:0] word_q [SETS];

         always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w)) begin
               for (int b = 0; b < LANES; b++)
                  if (wr_be[b]) word_q[wr_idx][8*b +: 8] <= wr_word[8*b +: 8];
            end
         end

         assign rd_word[w] = word_q[rd_idx];
      end
   endgenerate
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
   import cache2w_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int SET_BITS = 2,
   parameter int TAG_W    = 28
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cpu_valid,
   output logic                   cpu_ready,
   input  logic                   cpu_we,
   input  logic [LANES-1:0]       cpu_be,
   input  logic [ADDR_W-1:0]      cpu_addr,
   input  logic [WORD_W-1:0]      cpu_wdata,
   output logic                   cpu_resp_valid,
   output logic [WORD_W-1:0]      cpu_rdata,
   input  logic [1:0]             hit_way,
   input  logic                   vic_way,
   input  logic                   vic_valid,
   input  logic                   vic_dirty,
   input  logic [TAG_W-1:0]       vic_tag,
   output logic [SET_BITS-1:0]    lk_idx,
   output logic [TAG_W-1:0]       lk_tag,
   output logic                   tag_wr_en,
   output logic                   tag_wr_way,
   output logic [TAG_W-1:0]       tag_wr_tag,
   output logic                   tag_wr_dirty,
   output logic                   touch_en,
   output logic                   touch_way,
   input  logic [1:0][WORD_W-1:0] rd_word,
   output logic                   dat_wr_en,
   output logic                   dat_wr_way,
   output logic [LANES-1:0]       dat_wr_be,
   output logic [WORD_W-1:0]      dat_wr_word,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [WORD_W-1:0]      mem_wdata,
   input  logic                   mem_ack,
   input  logic [WORD_W-1:0]      mem_rdata
);
   cstate_e           state_q, state_d;
   logic              rq_we;
   logic [LANES-1:0]  rq_be;
   logic [ADDR_W-1:0] rq_addr;
   logic [WORD_W-1:0] rq_wdata;
   logic              rq_way;
   logic [TAG_W-1:0]  rq_vtag;
   logic [WORD_W-1:0] fill_q;
   logic [ADDR_W-1:0] lk_addr;
   logic              idle, accept, hit, hway, hit_wr;
   logic [WORD_W-1:0] fill_word;
   logic              unused_lowbits;

   assign idle      = (state_q == ST_IDLE);
   assign cpu_ready = idle;
   assign accept    = cpu_valid && idle;
   assign lk_addr   = idle ? cpu_addr : rq_addr;
   assign lk_idx    = lk_addr[SET_BITS+1:2];
   assign lk_tag    = lk_addr[ADDR_W-1:SET_BITS+2];
   assign unused_lowbits = ^{lk_addr[1:0], rq_addr[1:0]};

   assign hit    = |hit_way;
   assign hway   = hit_way[1];
   assign hit_wr = accept && hit && cpu_we;
   assign fill_word = merge_lanes(fill_q, rq_wdata, rq_we ? rq_be : '0);

   always_comb begin
      tag_wr_en    = 1'b0;
      tag_wr_way   = hway;
      tag_wr_tag   = lk_tag;
      tag_wr_dirty = 1'b1;
      touch_en     = accept && hit;
      touch_way    = hway;
      dat_wr_en    = hit_wr;
      dat_wr_way   = hway;
      dat_wr_be    = cpu_be;
      dat_wr_word  = cpu_wdata;
      tag_wr_en    = hit_wr;
      if (state_q == ST_FILL) begin
         tag_wr_en    = 1'b1;
         tag_wr_way   = rq_way;
         tag_wr_dirty = rq_we;
         touch_en     = 1'b1;
         touch_way    = rq_way;
         dat_wr_en    = 1'b1;
         dat_wr_way   = rq_way;
         dat_wr_be    = '1;
         dat_wr_word  = fill_word;
      end
   end

   always_comb begin
      mem_req   = (state_q == ST_WBACK) || (state_q == ST_FETCH);
      mem_we    = (state_q == ST_WBACK);
      mem_wdata = rd_word[rq_way];
      mem_addr  = mem_we ? {rq_vtag, lk_idx, 2'b00}
                         : {rq_addr[ADDR_W-1:2], 2'b00};
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept && !hit)
                      state_d = (vic_valid && vic_dirty) ? ST_WBACK : ST_FETCH;
         ST_WBACK: if (mem_ack) state_d = ST_FETCH;
         ST_FETCH: if (mem_ack) state_d = ST_FILL;
         ST_FILL:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q        <= ST_IDLE;
         cpu_resp_valid <= 1'b0;
      end else begin
         state_q        <= state_d;
         cpu_resp_valid <= (accept && hit) || (state_q == ST_FILL);
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         rq_we    <= cpu_we;
         rq_be    <= cpu_be;
         rq_addr  <= cpu_addr;
         rq_wdata <= cpu_wdata;
         rq_way   <= vic_way;
         rq_vtag  <= vic_tag;
      end
      if (state_q == ST_FETCH && mem_ack) fill_q <= mem_rdata;
      if (accept && hit)
         cpu_rdata <= cpu_we ? merge_lanes(rd_word[hway], cpu_wdata, cpu_be)
                             : rd_word[hway];
      else if (state_q == ST_FILL)
         cpu_rdata <= fill_word;
   end

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)))
      else $error("memory request dropped or changed before acknowledge"); // R8
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
   import cache2w_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int SET_BITS = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   output logic              cpu_ready,
   input  logic              cpu_we,
   input  logic [3:0]        cpu_be,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [31:0]       cpu_wdata,
   output logic              cpu_resp_valid,
   output logic [31:0]       cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata
);
   localparam int TAG_W = ADDR_W - SET_BITS - 2;

   initial begin : chk_params
      assert (SET_BITS >= 1 && SET_BITS <= 10) else $error("SET_BITS out of range");
      assert (TAG_W >= 1) else $error("ADDR_W too small for SET_BITS");
      assert (WORD_W == 32 && LANES == 4) else $error("word size must be 32 bits");
   end

   logic [SET_BITS-1:0]    lk_idx;
   logic [TAG_W-1:0]       lk_tag, vic_tag, tag_wr_tag;
   logic [1:0]             hit_way;
   logic                   vic_way, vic_valid, vic_dirty;
   logic                   tag_wr_en, tag_wr_way, tag_wr_dirty, touch_en, touch_way;
   logic [1:0][WORD_W-1:0] rd_word;
   logic                   dat_wr_en, dat_wr_way;
   logic [LANES-1:0]       dat_wr_be;
   logic [WORD_W-1:0]      dat_wr_word;

   cache2w_tags #(.SET_BITS(SET_BITS), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_tag(lk_tag),
      .hit_way(hit_way), .vic_way(vic_way), .vic_valid(vic_valid),
      .vic_dirty(vic_dirty), .vic_tag(vic_tag),
      .wr_en(tag_wr_en), .wr_idx(lk_idx), .wr_way(tag_wr_way),
      .wr_tag(tag_wr_tag), .wr_dirty(tag_wr_dirty),
      .touch_en(touch_en), .touch_idx(lk_idx), .touch_way(touch_way));

   cache2w_data #(.SET_BITS(SET_BITS)) u_data (
      .clk(clk), .rd_idx(lk_idx), .rd_word(rd_word),
      .wr_en(dat_wr_en), .wr_idx(lk_idx), .wr_way(dat_wr_way),
      .wr_be(dat_wr_be), .wr_word(dat_wr_word));

   cache2w_ctrl #(.ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .TAG_W(TAG_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
      .cpu_be(cpu_be), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_resp_valid(cpu_resp_valid), .cpu_rdata(cpu_rdata),
      .hit_way(hit_way), .vic_way(vic_way), .vic_valid(vic_valid),
      .vic_dirty(vic_dirty), .vic_tag(vic_tag),
      .lk_idx(lk_idx), .lk_tag(lk_tag),
      .tag_wr_en(tag_wr_en), .tag_wr_way(tag_wr_way), .tag_wr_tag(tag_wr_tag),
      .tag_wr_dirty(tag_wr_dirty), .touch_en(touch_en), .touch_way(touch_way),
      .rd_word(rd_word), .dat_wr_en(dat_wr_en), .dat_wr_way(dat_wr_way),
      .dat_wr_be(dat_wr_be), .dat_wr_word(dat_wr_word),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

   AST_HIT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_ready && (hit_way != 2'b00)) |=> (cpu_resp_valid && cpu_ready))
      else $error("hit did not respond next cycle"); // R6
   AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_ready && (hit_way == 2'b00)) |=> (!cpu_ready && !cpu_resp_valid))
      else $error("miss did not stall"); // R7
   AST_RESP_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_resp_valid |-> cpu_ready)
      else $error("response while busy"); // R7
   AST_NO_MEM_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_ready && (hit_way != 2'b00)) |=> !mem_req)
      else $error("memory touched on a hit"); // R5
endmodule

// File: tb/cache2w_top_tb_top.sv
`timescale 1ns/1ps
module cache2w_top_tb_top;
   localparam int MWORDS = 256;
   localparam int LAT    = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_valid = 1'b0, cpu_we = 1'b0;
   logic [3:0]  cpu_be = 4'h0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic        cpu_ready, cpu_resp_valid;
   logic [31:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #2.5 clk = ~clk;   // 200 MHz

   cache2w_top dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
      .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_resp_valid(cpu_resp_valid), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

   int          n_tests = 0, n_fail = 0;
   int          wb_cnt = 0, rd_cnt = 0, hs_viol = 0, cyc = 0;
   logic [31:0] mem [MWORDS];
   logic [31:0] ref_mem [MWORDS];
   logic [31:0] log_addr [2];
   logic        log_we [2];
   logic        pend = 1'b0, pend_we = 1'b0;
   logic [31:0] pend_addr = '0;
   int          lat = 0;
   bit          done = 0;

   function automatic logic [31:0] init_word(input int i);
      return 32'hC0DE_0000 ^ (i * 32'h0001_0203) ^ (i << 24);
   endfunction

   // word-wide memory model with fixed latency
   always @(posedge clk) begin
      if (mem_req && !mem_ack) begin
         if (pend && (mem_addr != pend_addr || mem_we != pend_we)) hs_viol++;
         pend = 1'b1; pend_addr = mem_addr; pend_we = mem_we;
      end else pend = 1'b0;
      if (!mem_req && pend) hs_viol++;
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         if (lat == LAT) begin
            lat = 0;
            mem_ack <= 1'b1;
            pend = 1'b0;
            log_addr[0] = log_addr[1]; log_we[0] = log_we[1];
            log_addr[1] = mem_addr;    log_we[1] = mem_we;
            if (mem_we) begin
               mem[mem_addr[9:2]] = mem_wdata;
               wb_cnt++;
            end else begin
               mem_rdata <= mem[mem_addr[9:2]];
               rd_cnt++;
            end
         end else lat++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: act cycles=%0d exp <150000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cpu_valid = 1'b0;
      for (int i = 0; i < MWORDS; i++) begin
         mem[i] = init_word(i); ref_mem[i] = init_word(i);
      end
      wb_cnt = 0; rd_cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic access(input logic we, input logic [31:0] addr, input logic [3:0] be,
                         input logic [31:0] wd, output logic was_hit, output logic [31:0] rd);
      int waited;
      int wi;
      wi = int'(addr[9:2]);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_be = be; cpu_wdata = wd;
      @(posedge clk);
      #1 cpu_valid = 1'b0;
      @(negedge clk);
      was_hit = cpu_resp_valid;
      if (was_hit) begin
         check(cpu_ready, "R6 ready high on hit", {31'd0, cpu_ready}, 32'd1);
      end else begin
         check(!cpu_ready, "R7 ready low on miss", {31'd0, cpu_ready}, 32'd0);
         waited = 0;
         while (!cpu_resp_valid && waited < 200) begin
            @(negedge clk);
            waited++;
            if (!cpu_resp_valid && cpu_ready)
               check(1'b0, "R7 ready rose before response", 32'd1, 32'd0);
         end
         check(cpu_resp_valid && cpu_ready, "R7 response with ready",
               {30'd0, cpu_resp_valid, cpu_ready}, 32'd3);
      end
      rd = cpu_rdata;
      if (we) begin
         for (int b = 0; b < 4; b++)
            if (be[b]) ref_mem[wi][8*b +: 8] = wd[8*b +: 8];
      end else begin
         check(rd == ref_mem[wi], "R11 read data", rd, ref_mem[wi]);
      end
   endtask

   task automatic t_reset();
      logic h; logic [31:0] d;
      do_reset();
      @(negedge clk);
      check(cpu_ready && !cpu_resp_valid && !mem_req, "R1 idle after reset",
            {29'd0, cpu_ready, cpu_resp_valid, mem_req}, 32'h4);
      access(1'b0, 32'h0000_0080, 4'h0, '0, h, d);
      check(!h, "R1 first access misses", {31'd0, h}, 32'd0);
   endtask

   task automatic t_pingpong();
      logic h; logic [31:0] d;
      int miss = 0, hits = 0, first2 = 0;
      do_reset();
      for (int k = 0; k < 8; k++) begin
         access(1'b0, (k % 2 == 0) ? 32'h0 : 32'h10, 4'h0, '0, h, d);
         if (h) hits++; else begin miss++; if (k < 2) first2++; end
      end
      check(miss == 2 && first2 == 2, "R3 two misses first", miss, 2);
      check(hits == 6, "R3 six hits", hits, 6);
   endtask

   task automatic t_lru();
      logic h; logic [31:0] d;
      do_reset();
      access(1'b0, 32'h00, 4'h0, '0, h, d);
      access(1'b0, 32'h10, 4'h0, '0, h, d);
      access(1'b0, 32'h00, 4'h0, '0, h, d);
      check(h, "R4 A resident", {31'd0, h}, 32'd1);
      access(1'b0, 32'h20, 4'h0, '0, h, d);
      check(!h, "R4 C misses", {31'd0, h}, 32'd0);
      access(1'b0, 32'h00, 4'h0, '0, h, d);
      check(h, "R4 recent way kept", {31'd0, h}, 32'd1);
      access(1'b0, 32'h10, 4'h0, '0, h, d);
      check(!h, "R4 least recent evicted", {31'd0, h}, 32'd0);
   endtask

   task automatic t_write_hit_and_wb();
      logic h; logic [31:0] d;
      int wb0;
      do_reset();
      access(1'b0, 32'h04, 4'h0, '0, h, d);
      wb0 = wb_cnt;
      access(1'b1, 32'h04, 4'b0011, 32'hDEAD_BEEF, h, d);
      check(h, "R5 write hit", {31'd0, h}, 32'd1);
      check(wb_cnt == wb0 && mem[1] == init_word(1), "R5 no memory write", mem[1], init_word(1));
      access(1'b0, 32'h04, 4'h0, '0, h, d);
      check(d == {init_word(1)[31:16], 16'hBEEF}, "R5 lanes merged", d,
            {init_word(1)[31:16], 16'hBEEF});
      access(1'b0, 32'h14, 4'h0, '0, h, d);
      access(1'b0, 32'h24, 4'h0, '0, h, d);
      check(wb_cnt == 1, "R9 dirty victim written", wb_cnt, 1);
      check(mem[1] == ref_mem[1], "R9 written data", mem[1], ref_mem[1]);
      check(log_we[0] && log_addr[0] == 32'h04 && !log_we[1] && log_addr[1] == 32'h24,
            "R9 write-back before fetch", log_addr[0], 32'h04);
      access(1'b0, 32'h14, 4'h0, '0, h, d);
      access(1'b0, 32'h34, 4'h0, '0, h, d);
      check(wb_cnt == 1, "R9 clean victim not written", wb_cnt, 1);
   endtask

   task automatic t_write_miss();
      logic h; logic [31:0] d;
      do_reset();
      access(1'b1, 32'h08, 4'b1100, 32'h1234_5678, h, d);
      check(!h && rd_cnt == 1, "R10 write miss fetches", rd_cnt, 1);
      check(wb_cnt == 0 && mem[2] == init_word(2), "R10 memory untouched", mem[2], init_word(2));
      access(1'b0, 32'h08, 4'h0, '0, h, d);
      check(h, "R10 allocated line hits", {31'd0, h}, 32'd1);
      access(1'b0, 32'h18, 4'h0, '0, h, d);
      access(1'b0, 32'h28, 4'h0, '0, h, d);
      check(wb_cnt == 1 && mem[2] == {16'h1234, init_word(2)[15:0]},
            "R10 dirty on eviction", mem[2], {16'h1234, init_word(2)[15:0]});
   endtask

   task automatic t_addr_split();
      logic h; logic [31:0] d;
      do_reset();
      access(1'b0, 32'h40, 4'h0, '0, h, d);
      access(1'b0, 32'h43, 4'h0, '0, h, d);
      check(h, "R2 byte offset ignored", {31'd0, h}, 32'd1);
      access(1'b0, 32'h140, 4'h0, '0, h, d);
      check(!h, "R2 tag differs misses", {31'd0, h}, 32'd0);
      access(1'b0, 32'h44, 4'h0, '0, h, d);
      check(!h, "R2 next set misses", {31'd0, h}, 32'd0);
   endtask

   task automatic t_random();
      logic h; logic [31:0] d;
      logic [31:0] lf = 32'h1ACE_B00C;
      do_reset();
      for (int k = 0; k < 400; k++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         access(lf[9] & lf[10], {25'd0, lf[6:2], 2'b00}, lf[15:12], lf ^ 32'h5A5A_0F0F, h, d);
      end
      check(hs_viol == 0, "R8 request held until acknowledge", hs_viol, 0);
   endtask

   initial begin
      log_addr[0] = '0; log_addr[1] = '0; log_we[0] = 0; log_we[1] = 0;
      t_reset();
      t_pingpong();
      t_lru();
      t_write_hit_and_wb();
      t_write_miss();
      t_addr_split();
      t_random();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule